// File: doc/BRIEF.md
# Externally Clocked Serial Shift Transmitter

This block sends words of 1 to 32 bits on a single data pin, least significant bit first. It does not generate a bit clock. An external master drives a separate serial clock pin, which has no fixed phase relation to the system clock. The block synchronizes that pin and detects its edges. Each qualifying edge presents the next bit on the data pin. A configuration input inverts the sampled clock, so the block can advance on the falling edge of the external clock instead of the rising edge.

Software writes a word and its length into a holding register. That register accepts a write at any time. When the shifter has sent the last bit of its current word, the next qualifying edge moves the held word into the shifter and its bit 0 appears on the pin. The stream therefore has no gap, provided each new word arrives before the previous word runs out.

Two flags report the buffer state:
- A buffer-empty flag rises when the holding register has been moved into the shifter.
- An underrun flag rises when a qualifying edge finds nothing left to send. In that case the pin keeps its last bit.

While the transmit enable is low, the pin follows an ordinary output register value and clock edges are ignored.

Top module: `ser_shift_tx`

## Requirements
- R1: The length field `cfg_len_i` holds the bit count minus one (0 selects 1 bit, DATA_W-1 selects DATA_W bits). It is captured together with the word on a write. Only that many low-order bits of the word are sent.
- R2: The bits of a word appear on the data pin starting at bit 0 and moving toward higher bit positions, one bit per qualifying edge.
- R3: Consider a transition of the clock pin that is set up before system clock edge E0, so that it is registered at E0. The resulting bit change appears on `pin_o` after edge E0+2 and not before.
- R4: With `cfg_sclk_inv_i` = 1, a falling transition of `sclk_i` is the qualifying edge and a rising transition moves nothing. With `cfg_sclk_inv_i` = 0, the reverse holds.
- R5: While `tx_en_i` = 1, `pin_o` shows the current shifter bit. While `tx_en_i` = 0, `pin_o` equals `out_reg_i`.
- R6: While `tx_en_i` = 0, edges on `sclk_i` are ignored. After the enable returns, the pin shows the same bit as before, and the next edge sends the following bit of the word.
- R7: On the qualifying edge after the last bit of a word, a held word moves into the shifter and its bit 0 appears on the pin, with no idle bit in between.
- R8: `buf_empty_o` is 0 after reset. It becomes 1 on the cycle after the held word moves into the shifter. It becomes 0 on the cycle after a write. A write takes priority over a move in the same cycle.
- R9: A qualifying edge that finds the current word finished and no word held sets `underrun_o` to 1 and leaves `pin_o` on the last bit sent. The next write clears `underrun_o`.
- R10: Reset clears the shifter, the holding register and both flags. With the block enabled, `pin_o` reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside the block |
| sclk_i | input | 1 | Serial clock driven by the external master, asynchronous to `clk_i` |
| cfg_sclk_inv_i | input | 1 | 1 selects the falling edge of `sclk_i` as the qualifying edge |
| tx_en_i | input | 1 | Transmit enable: the block owns the pin and reacts to edges |
| out_reg_i | input | 1 | Ordinary output value shown on the pin while the block is disabled |
| load_valid_i | input | 1 | Write strobe for the holding register |
| load_data_i | input | DATA_W | Word to send |
| cfg_len_i | input | $clog2(DATA_W) | Word length minus one |
| pin_o | output | 1 | Data pin |
| buf_empty_o | output | 1 | Holding register has been moved into the shifter |
| underrun_o | output | 1 | A qualifying edge found nothing to send |

## Verification
The bench runs every word length of an 8-bit configuration. For each length it streams two words with complementary bit patterns back to back. This separates a correct bit order and length cut-off from shifts that are off by one position and from words that are cut short. The same run shows whether the reload from the holding register inserts a gap. An extra edge at the end of each stream separates underrun handling from a shifter that keeps shifting in zeros. A single latency probe samples the pin one cycle before and exactly at the promised cycle. An inverted-clock pass and a pass with edges sent while disabled show that non-qualifying edges move nothing.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  // Number of flops that sample the asynchronous serial clock before edge detection.
  localparam int unsigned SYNC_STAGES = 2;

  // What the shifter does on a given cycle.
  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,  // no qualifying edge this cycle
    ACT_SHIFT  = 2'd1,  // advance to the next bit of the current word
    ACT_LOAD   = 2'd2,  // current word finished, take the held word
    ACT_STARVE = 2'd3   // current word finished, nothing held
  } shift_act_e;

endpackage

// File: rtl/ser_tx_edge.sv
module ser_tx_edge #(
  parameter int unsigned SYNC_W = ser_tx_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic inv_i,
  input  logic en_i,
  output logic edge_o
);

  logic [SYNC_W-1:0] sync_q;
  logic [SYNC_W-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;
  logic              level;

  // Polarity is applied before the first flop so that both polarities see the same latency.
  always_comb begin
    sync_d = {sync_q[SYNC_W-2:0], sclk_i ^ inv_i};
    level  = sync_q[SYNC_W-1];
    prev_d = level;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign edge_o = en_i & level & ~prev_q;

endmodule

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0]  wr_len_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  len_o,
  output logic              empty_o
);

  logic              full_q, full_d;
  logic              empty_q, empty_d;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  len_q;

  // A write on the same cycle as a take wins: the fresh word stays held.
  always_comb begin
    full_d  = full_q;
    empty_d = empty_q;
    if (take_i) begin
      full_d  = 1'b0;
      empty_d = 1'b1;
    end
    if (wr_i) begin
      full_d  = 1'b1;
      empty_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q  <= 1'b0;
      empty_q <= 1'b0;
    end else begin
      full_q  <= full_d;
      empty_q <= empty_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      len_q  <= '0;
    end else if (wr_i) begin
      data_q <= wr_data_i;
      len_q  <= wr_len_i;
    end
  end

  assign full_o  = full_q;
  assign data_o  = data_q;
  assign len_o   = len_q;
  assign empty_o = empty_q;

endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
  import ser_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              edge_i,
  input  logic              wr_i,
  input  logic              held_full_i,
  input  logic [DATA_W-1:0] held_data_i,
  input  logic [CNT_W-1:0]  held_len_i,
  output logic              take_o,
  output logic              bit_o,
  output logic              underrun_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  shift_act_e        act;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              und_q, und_d;
  logic              word_done;
  logic              sh_en;

  assign word_done = (rem_q == '0);

  always_comb begin
    if (!edge_i)          act = ACT_IDLE;
    else if (!word_done)  act = ACT_SHIFT;
    else if (held_full_i) act = ACT_LOAD;
    else                  act = ACT_STARVE;
  end

  always_comb begin
    sh_d  = sh_q;
    rem_d = rem_q;
    sh_en = 1'b0;
    unique case (act)
      ACT_SHIFT: begin
        sh_d  = {1'b0, sh_q[DATA_W-1:1]};
        rem_d = rem_q - CNT_ONE;
        sh_en = 1'b1;
      end
      ACT_LOAD: begin
        sh_d  = held_data_i;
        rem_d = held_len_i;
        sh_en = 1'b1;
      end
      default: begin
        sh_en = 1'b0;
      end
    endcase
  end

  // A write on the same cycle as a starved edge wins, so the flag stays clear.
  always_comb begin
    und_d = und_q;
    if (act == ACT_STARVE) und_d = 1'b1;
    if (wr_i)              und_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (sh_en) begin
      sh_q  <= sh_d;
      rem_q <= rem_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) und_q <= 1'b0;
    else         und_q <= und_d;
  end

  assign take_o     = (act == ACT_LOAD);
  assign bit_o      = sh_q[0];
  assign underrun_o = und_q;

endmodule

// File: rtl/ser_shift_tx.sv
module ser_shift_tx #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cfg_sclk_inv_i,
  input  logic              tx_en_i,
  input  logic              out_reg_i,
  input  logic              load_valid_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic [CNT_W-1:0]  cfg_len_i,
  output logic              pin_o,
  output logic              buf_empty_o,
  output logic              underrun_o
);

  // Reset is asserted at once and released two clock edges later.
  logic [1:0]        rst_pipe_q;
  logic              rst_n_int;
  logic              edge_w;
  logic              take_w;
  logic              held_full_w;
  logic [DATA_W-1:0] held_data_w;
  logic [CNT_W-1:0]  held_len_w;
  logic              shift_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  ser_tx_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .sclk_i (sclk_i),
    .inv_i  (cfg_sclk_inv_i),
    .en_i   (tx_en_i),
    .edge_o (edge_w)
  );

  ser_tx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .wr_i      (load_valid_i),
    .wr_data_i (load_data_i),
    .wr_len_i  (cfg_len_i),
    .take_i    (take_w),
    .full_o    (held_full_w),
    .data_o    (held_data_w),
    .len_o     (held_len_w),
    .empty_o   (buf_empty_o)
  );

  ser_tx_shift #(.DATA_W(DATA_W)) i_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .edge_i      (edge_w),
    .wr_i        (load_valid_i),
    .held_full_i (held_full_w),
    .held_data_i (held_data_w),
    .held_len_i  (held_len_w),
    .take_o      (take_w),
    .bit_o       (shift_bit),
    .underrun_o  (underrun_o)
  );

  assign pin_o = tx_en_i ? shift_bit : out_reg_i;

endmodule

// File: rtl/ser_shift_tx_chk.sv
module ser_shift_tx_chk (
  input logic clk_i,
  input logic rst_n,
  input logic edge_w,
  input logic bit_w,
  input logic tx_en_i,
  input logic load_valid_i,
  input logic buf_empty_o,
  input logic underrun_o
);

  // R3: the shifter bit moves only on the cycle after a detected edge.
  p_bit_moves_on_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !edge_w |=> $stable(bit_w));

  // R6: while disabled, the shifter keeps its bit.
  p_disabled_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !tx_en_i |=> $stable(bit_w));

  // R8: a write clears the empty flag on the next cycle.
  p_write_clears_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    load_valid_i |=> !buf_empty_o);

  // R8: the empty flag rises only after a qualifying edge.
  p_empty_rises_on_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(buf_empty_o) |-> $past(edge_w));

  // R9: a write clears the underrun flag on the next cycle.
  p_write_clears_underrun_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    load_valid_i |=> !underrun_o);

  // R9: the underrun flag rises only after a qualifying edge.
  p_underrun_needs_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(underrun_o) |-> $past(edge_w));

endmodule

bind ser_shift_tx ser_shift_tx_chk i_chk (
  .clk_i        (clk_i),
  .rst_n        (rst_n_int),
  .edge_w       (edge_w),
  .bit_w        (shift_bit),
  .tx_en_i      (tx_en_i),
  .load_valid_i (load_valid_i),
  .buf_empty_o  (buf_empty_o),
  .underrun_o   (underrun_o)
);

// File: tb/test_ser_shift_tx.sv
module test_ser_shift_tx;

  localparam int unsigned DW = 8;
  localparam int unsigned CW = $clog2(DW);

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          sclk_i;
  logic          cfg_sclk_inv_i;
  logic          tx_en_i;
  logic          out_reg_i;
  logic          load_valid_i;
  logic [DW-1:0] load_data_i;
  logic [CW-1:0] cfg_len_i;
  logic          pin_o;
  logic          buf_empty_o;
  logic          underrun_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  ser_shift_tx #(.DATA_W(DW)) i_ser_shift_tx (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sclk_i         (sclk_i),
    .cfg_sclk_inv_i (cfg_sclk_inv_i),
    .tx_en_i        (tx_en_i),
    .out_reg_i      (out_reg_i),
    .load_valid_i   (load_valid_i),
    .load_data_i    (load_data_i),
    .cfg_len_i      (cfg_len_i),
    .pin_o          (pin_o),
    .buf_empty_o    (buf_empty_o),
    .underrun_o     (underrun_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_raw(input logic v);
    @(negedge clk_i);
    sclk_i = v;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic pulse();
    set_raw(1'b1);
    set_raw(1'b0);
  endtask

  task automatic write_word(input logic [DW-1:0] d, input logic [CW-1:0] len);
    @(negedge clk_i);
    load_valid_i = 1'b1;
    load_data_i  = d;
    cfg_len_i    = len;
    @(negedge clk_i);
    load_valid_i = 1'b0;
  endtask

  initial begin
    #(10 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] wa, wb;
    rst_ni = 1'b0;
    sclk_i = 1'b0;
    cfg_sclk_inv_i = 1'b0;
    tx_en_i = 1'b0;
    out_reg_i = 1'b0;
    load_valid_i = 1'b0;
    load_data_i = '0;
    cfg_len_i = '0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R5: pin follows the output register while disabled
    out_reg_i = 1'b1; #1; chk("R5 disabled pin=1", pin_o, 1'b1);
    out_reg_i = 1'b0; #1; chk("R5 disabled pin=0", pin_o, 1'b0);

    // R10: reset state
    tx_en_i = 1'b1; #1;
    chk("R10 pin after reset", pin_o, 1'b0);
    chk("R10 buf_empty after reset", buf_empty_o, 1'b0);
    chk("R10 underrun after reset", underrun_o, 1'b0);

    // R3: latency probe, one cycle early and exactly on time
    write_word(8'h01, 3'd0);
    @(negedge clk_i);
    sclk_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R3 pin before E0+2", pin_o, 1'b0);
    @(negedge clk_i);
    chk("R3 pin after E0+2", pin_o, 1'b1);
    set_raw(1'b0);

    // R1 R2 R7 R8 R9: every length, two streamed words, then one starved edge
    for (int len = 1; len <= int'(DW); len++) begin
      wa = DW'((len * 8'h35) ^ 8'h5A);
      wb = ~wa;
      write_word(wa, CW'(len - 1));
      chk("R9 write clears underrun", underrun_o, 1'b0);
      pulse();
      chk("R7 first word bit 0", pin_o, wa[0]);
      chk("R8 empty after move", buf_empty_o, 1'b1);
      write_word(wb, CW'(len - 1));
      chk("R8 empty cleared by write", buf_empty_o, 1'b0);
      for (int i = 1; i < len; i++) begin
        pulse();
        chk("R2 R1 first word bit", pin_o, wa[i]);
      end
      for (int i = 0; i < len; i++) begin
        pulse();
        if (i == 0) begin
          chk("R7 gap-free reload", pin_o, wb[0]);
          chk("R8 empty after reload", buf_empty_o, 1'b1);
        end else begin
          chk("R2 R1 second word bit", pin_o, wb[i]);
        end
      end
      chk("R9 no underrun before starved edge", underrun_o, 1'b0);
      pulse();
      chk("R9 underrun set", underrun_o, 1'b1);
      chk("R9 pin holds last bit", pin_o, wb[len - 1]);
    end

    // R6: edges ignored while disabled
    write_word(8'h06, 3'd3);
    pulse();
    chk("R6 bit 0 before disable", pin_o, 1'b0);
    tx_en_i = 1'b0;
    out_reg_i = 1'b1;
    #1; chk("R5 override while disabled", pin_o, 1'b1);
    pulse();
    tx_en_i = 1'b1;
    out_reg_i = 1'b0;
    #1; chk("R6 bit kept after ignored edge", pin_o, 1'b0);
    pulse(); chk("R6 next bit after enable", pin_o, 1'b1);
    pulse(); chk("R6 bit 2", pin_o, 1'b1);
    pulse(); chk("R6 bit 3", pin_o, 1'b0);

    // R4: inverted clock, change polarity and level together so the sampled level stays low
    @(negedge clk_i);
    cfg_sclk_inv_i = 1'b1;
    sclk_i = 1'b1;
    repeat (3) @(negedge clk_i);
    write_word(8'h02, 3'd1);
    set_raw(1'b0);
    chk("R4 falling edge loads bit 0", pin_o, 1'b0);
    chk("R4 empty after move", buf_empty_o, 1'b1);
    set_raw(1'b1);
    chk("R4 rising edge moves nothing", pin_o, 1'b0);
    set_raw(1'b0);
    chk("R4 falling edge shifts bit 1", pin_o, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule